// File: doc/BRIEF.md
# Disk Format Sequencer Address and Branch Control

This block produces the 8-bit address for a microcoded disk format sequencer. It runs on the device bit clock. An internal divider makes a byte strobe on every eighth bit clock, and the low seven address bits can change only on that strobe. They step by one each byte. A fixed entry address is loaded when a sector mark arrives. A fixed end address is loaded when the microword signals the end of a sequence. On the byte after that end address, a separate fixed resume address is loaded.

Address bit 7 is the branch condition that the control store sees. It normally comes from a 4-bit byte counter. The microword loads this counter, and it counts up to its terminal value of 15. Bit 7 can instead come from a sync detector that watches the serial read data. That happens when the microword has armed branch-on-sync and the sync window is open. The control store and the data path sit outside this block.

Top module: `fmtseq_branch`

## Requirements
- R1: While `rst` is high at a clock edge, the block clears its state. After reset, `seq_addr` reads 8'h00.
- R2: A byte strobe occurs on every eighth rising edge after reset is released, the first on the eighth edge. `seq_addr[6:0]` changes only on a byte strobe.
- R3: On a byte strobe with no sector mark, no sequence end and no resume pending, `seq_addr[6:0]` increments by one, modulo 128.
- R4: A sector mark seen on any bit clock since the previous byte strobe loads `seq_addr[6:0]` = 7'h01 on the next byte strobe. This is 8'o201 when the branch bit is set.
- R5: `seq_end` high on a byte strobe, with no sector mark, loads `seq_addr[6:0]` = 7'h7E.
- R6: On the byte strobe after the end address is loaded, with no mark and no new end, `seq_addr[6:0]` becomes the resume address 7'h11, not the entry address.
- R7: A sector mark wins over `seq_end` on the same byte strobe. It also cancels any pending resume, so the following byte simply increments.
- R8: `cnt_load` high on a byte strobe loads the counter from `cnt_field`. Every other byte strobe adds one, up to 15. When not gated by sync, `seq_addr[7]` is 1 exactly when the counter is 15. After a load of v, it rises on the (15-v)th following byte strobe; a load of 15 sets it at once.
- R9: The counter holds at 15 until it is reloaded, so `seq_addr[7]` stays high.
- R10: `br_sync` high on a byte strobe without `cnt_load` arms a sync gate. While the gate is armed and `sync_win` is high, `seq_addr[7]` equals the sync-found flag and ignores the counter.
- R11: The sync-found flag sets when the last eight `rd_data` bits, oldest first, are 1,1,0,0,1,1,0,0 while `sync_win` is high. A single 1,1,0,0 does not set it.
- R12: A counter load clears both the sync gate and the sync-found flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device bit clock |
| rst | input | 1 | Synchronous active-high reset |
| sector_mark | input | 1 | Sector mark seen on the media |
| seq_end | input | 1 | Microword end-of-sequence flag |
| cnt_load | input | 1 | Microword request to load the byte counter |
| cnt_field | input | 4 | Microword count field |
| br_sync | input | 1 | Microword request to branch on sync |
| sync_win | input | 1 | Sync search window open |
| rd_data | input | 1 | Serial read data, one bit per clock |
| seq_addr | output | 8 | Sequencer address; bit 7 is the branch condition |

## Verification
A wrong byte phase moves every address change off the eight-clock grid, and the bench sees it at the first strobe. A lost resume flag or a wrong source priority gives a wrong low address on the very next byte. A counter fault shows up as `seq_addr[7]` rising one or more bytes early or late, or dropping after terminal count. A fault in the sync flag or the gate shows up in bit 7 while the window is open, within the byte in which the pattern completes or the load happens.

// File: rtl/fsq_pkg.sv
`timescale 1ns/1ps
package fsq_pkg;

  typedef enum logic [1:0] {
    SRC_STEP   = 2'd0,
    SRC_MARK   = 2'd1,
    SRC_END    = 2'd2,
    SRC_RESUME = 2'd3
  } addr_src_e;

  // priority: mark, then end, then resume, else step
  function automatic addr_src_e pick_src(input logic mark, input logic fin,
                                         input logic resume);
    if (mark)        return SRC_MARK;
    else if (fin)    return SRC_END;
    else if (resume) return SRC_RESUME;
    else             return SRC_STEP;
  endfunction

  function automatic int unsigned sat_inc(input int unsigned v,
                                          input int unsigned top);
    return (v >= top) ? top : v + 1;
  endfunction

endpackage

// File: rtl/fsq_byte_timer.sv
`timescale 1ns/1ps
module fsq_byte_timer #(
  parameter int BITS_PER_BYTE = 8
) (
  input  logic clk,
  input  logic rst,
  output logic byte_stb
);
  localparam int DW = (BITS_PER_BYTE > 1) ? $clog2(BITS_PER_BYTE) : 1;
  localparam logic [DW-1:0] LAST = DW'(BITS_PER_BYTE - 1);

  logic [DW-1:0] phase_q;

  always_ff @(posedge clk) begin
    if (rst)                phase_q <= '0;
    else if (phase_q == LAST) phase_q <= '0;
    else                    phase_q <= phase_q + 1'b1;
  end

  assign byte_stb = (phase_q == LAST);

  // R2
  stb_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    byte_stb |=> !byte_stb);
endmodule

// File: rtl/fsq_addr_sel.sv
`timescale 1ns/1ps
module fsq_addr_sel
  import fsq_pkg::*;
#(
  parameter int          AW         = 7,
  parameter logic [AW-1:0] MARK_BASE   = 7'h01,
  parameter logic [AW-1:0] END_BASE    = 7'h7E,
  parameter logic [AW-1:0] RESUME_BASE = 7'h11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          byte_stb,
  input  logic          sector_mark,
  input  logic          seq_end,
  output logic [AW-1:0] base_addr
);
  logic          mark_pend_q;
  logic          resume_q;
  logic [AW-1:0] base_q;
  logic          mark_seen;
  addr_src_e     src;

  assign mark_seen = mark_pend_q | sector_mark;
  assign src       = pick_src(mark_seen, seq_end, resume_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      mark_pend_q <= 1'b0;
      resume_q    <= 1'b0;
      base_q      <= '0;
    end else if (byte_stb) begin
      mark_pend_q <= 1'b0;
      resume_q    <= (src == SRC_END);
      unique case (src)
        SRC_MARK:   base_q <= MARK_BASE;
        SRC_END:    base_q <= END_BASE;
        SRC_RESUME: base_q <= RESUME_BASE;
        default:    base_q <= base_q + 1'b1;
      endcase
    end else begin
      mark_pend_q <= mark_seen;
    end
  end

  assign base_addr = base_q;

  // R1
  base_reset_chk: assert property (@(posedge clk) rst |=> (base_q == '0));
  // R2
  base_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !byte_stb |=> $stable(base_q));
  // R5
  end_load_chk: assert property (@(posedge clk) disable iff (rst)
    (byte_stb && !mark_seen && seq_end) |=> (base_q == END_BASE));
  // R7
  mark_first_chk: assert property (@(posedge clk) disable iff (rst)
    (byte_stb && mark_seen) |=> (base_q == MARK_BASE && !resume_q));
endmodule

// File: rtl/fsq_branch_ctl.sv
`timescale 1ns/1ps
module fsq_branch_ctl
  import fsq_pkg::*;
#(
  parameter int          CW        = 4,
  parameter int          PAT_W     = 8,
  parameter logic [PAT_W-1:0] SYNC_PAT = 8'b1100_1100
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          byte_stb,
  input  logic          cnt_load,
  input  logic [CW-1:0] cnt_field,
  input  logic          br_sync,
  input  logic          sync_win,
  input  logic          rd_data,
  output logic          branch
);
  localparam int unsigned TOP = (1 << CW) - 1;

  logic [CW-1:0]    cnt_q;
  logic             gate_q;
  logic             found_q;
  logic [PAT_W-2:0] hist_q;
  logic             load_now;
  logic             sync_hit;
  logic             at_top;

  assign load_now = byte_stb & cnt_load;
  assign sync_hit = sync_win & ({hist_q, rd_data} == SYNC_PAT);
  assign at_top   = (cnt_q == CW'(TOP));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      gate_q  <= 1'b0;
      found_q <= 1'b0;
      hist_q  <= '0;
    end else begin
      hist_q <= {hist_q[PAT_W-3:0], rd_data};
      if (load_now) begin
        cnt_q   <= cnt_field;
        gate_q  <= 1'b0;
        found_q <= 1'b0;
      end else begin
        if (byte_stb) begin
          cnt_q  <= CW'(sat_inc(int'(cnt_q), TOP));
          gate_q <= gate_q | br_sync;
        end
        if (sync_hit) found_q <= 1'b1;
      end
    end
  end

  assign branch = (gate_q & sync_win) ? found_q : at_top;

  // R9
  top_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (at_top && !load_now) |=> at_top);
  // R8
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    (byte_stb && !load_now && !at_top) |=> (cnt_q == $past(cnt_q) + 1'b1));
  // R11
  found_window_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(found_q) |-> $past(sync_win));
  // R12
  load_clears_chk: assert property (@(posedge clk) disable iff (rst)
    load_now |=> (!gate_q && !found_q));
endmodule

// File: rtl/fmtseq_branch.sv
`timescale 1ns/1ps
module fmtseq_branch #(
  parameter int BITS_PER_BYTE = 8,
  parameter int ADDR_W        = 8,
  parameter int CNT_W         = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sector_mark,
  input  logic             seq_end,
  input  logic             cnt_load,
  input  logic [CNT_W-1:0] cnt_field,
  input  logic             br_sync,
  input  logic             sync_win,
  input  logic             rd_data,
  output logic [ADDR_W-1:0] seq_addr
);
  localparam int BW = ADDR_W - 1;

  logic          byte_stb;
  logic [BW-1:0] base_addr;
  logic          branch;

  fsq_byte_timer #(.BITS_PER_BYTE(BITS_PER_BYTE)) u_timer (
    .clk(clk), .rst(rst), .byte_stb(byte_stb)
  );

  fsq_addr_sel #(
    .AW(BW),
    .MARK_BASE(BW'(7'h01)),
    .END_BASE(BW'(7'h7E)),
    .RESUME_BASE(BW'(7'h11))
  ) u_addr (
    .clk(clk), .rst(rst), .byte_stb(byte_stb),
    .sector_mark(sector_mark), .seq_end(seq_end),
    .base_addr(base_addr)
  );

  fsq_branch_ctl #(.CW(CNT_W)) u_branch (
    .clk(clk), .rst(rst), .byte_stb(byte_stb),
    .cnt_load(cnt_load), .cnt_field(cnt_field),
    .br_sync(br_sync), .sync_win(sync_win), .rd_data(rd_data),
    .branch(branch)
  );

  assign seq_addr = {branch, base_addr};

  // R10
  gate_blocks_chk: assert property (@(posedge clk) disable iff (rst)
    (sync_win && $stable(sync_win) && $past(br_sync && byte_stb && !cnt_load)
     && !$past(seq_addr[ADDR_W-1])) |-> !seq_addr[ADDR_W-1]);
endmodule

// File: tb/sim_fmtseq_branch.sv
`timescale 1ns/1ps
module sim_fmtseq_branch;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sector_mark = 1'b0, seq_end = 1'b0, cnt_load = 1'b0;
  logic [3:0] cnt_field = 4'd0;
  logic       br_sync = 1'b0, sync_win = 1'b0, rd_data = 1'b0;
  logic [7:0] seq_addr;

  int total = 0;
  int bad   = 0;

  typedef struct { logic [7:0] exp; string tag; } item_t;
  item_t q[$];
  event  sample_ev;

  logic [6:0] eb = 7'h00;
  logic       eres = 1'b0;

  always #4 clk = ~clk;

  fmtseq_branch u0 (
    .clk(clk), .rst(rst), .sector_mark(sector_mark), .seq_end(seq_end),
    .cnt_load(cnt_load), .cnt_field(cnt_field), .br_sync(br_sync),
    .sync_win(sync_win), .rd_data(rd_data), .seq_addr(seq_addr)
  );

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: seq_addr=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops expected items when the driver signals a finished byte
  initial forever begin
    @(sample_ev);
    while (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      check(seq_addr, it.exp, it.tag);
    end
  end

  // one byte time: inputs held, rd bits sent oldest first
  task automatic run_byte(input logic mk, input logic se, input logic ld,
                          input logic [3:0] cf, input logic bs, input logic win,
                          input logic [7:0] bits, input logic exp7, input string tag);
    item_t it;
    sector_mark = mk; seq_end = se; cnt_load = ld; cnt_field = cf;
    br_sync = bs; sync_win = win;
    for (int i = 7; i >= 0; i--) begin
      rd_data = bits[i];
      @(negedge clk);
    end
    if (mk)        begin eb = 7'h01; eres = 1'b0; end
    else if (se)   begin eb = 7'h7E; eres = 1'b1; end
    else if (eres) begin eb = 7'h11; eres = 1'b0; end
    else           eb = eb + 7'd1;
    it.exp = {exp7, eb};
    it.tag = tag;
    q.push_back(it);
    -> sample_ev;
    #1;
  endtask

  task automatic load_run(input int v);
    run_byte(0, 0, 1, 4'(v), 0, 0, 8'h00, v == 15, "R8 load");
    for (int k = 1; k <= 15 - v; k++)
      run_byte(0, 0, 0, 4'd0, 0, 0, 8'h00, k == 15 - v, "R8 count");
  endtask

  initial begin
    #(8 * 200000);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(seq_addr, 8'h00, "R1 reset");
    rst = 1'b0;
    // seven edges: no strobe yet, address must hold
    repeat (7) @(negedge clk);
    check(seq_addr, 8'h00, "R2 no early strobe");
    // eighth edge is the first strobe: plain step
    @(negedge clk);
    eb = 7'h01;
    check(seq_addr, 8'h01, "R2 R3 first strobe");
    // counter now 1
    run_byte(1, 0, 0, 4'd0, 0, 0, 8'h00, 0, "R4 mark");
    run_byte(0, 0, 0, 4'd0, 0, 0, 8'h00, 0, "R3 step");
    run_byte(0, 1, 0, 4'd0, 0, 0, 8'h00, 0, "R5 end");
    run_byte(0, 0, 0, 4'd0, 0, 0, 8'h00, 0, "R6 resume");
    run_byte(1, 1, 0, 4'd0, 0, 0, 8'h00, 0, "R7 priority");
    run_byte(0, 0, 0, 4'd0, 0, 0, 8'h00, 0, "R7 no resume");
    load_run(0);
    for (int k = 0; k < 3; k++)
      run_byte(0, 0, 0, 4'd0, 0, 0, 8'h00, 1, "R9 hold");
    load_run(8);
    load_run(4);
    load_run(14);
    load_run(15);
    // sync gating
    run_byte(0, 0, 0, 4'd0, 1, 1, 8'h00, 0, "R10 gate arms");
    run_byte(0, 0, 0, 4'd0, 0, 1, 8'h0C, 0, "R11 single nibble");
    run_byte(0, 0, 0, 4'd0, 0, 1, 8'hCC, 1, "R11 sync found");
    run_byte(0, 0, 1, 4'd15, 0, 1, 8'h00, 1, "R12 gate cleared");
    run_byte(0, 0, 0, 4'd0, 1, 1, 8'h00, 0, "R12 found cleared");
    run_byte(0, 0, 0, 4'd0, 0, 0, 8'h00, 1, "R10 window closed");
    run_byte(0, 0, 0, 4'd0, 0, 1, 8'h00, 0, "R10 window reopened");
    @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule